// File: doc/BRIEF.md
# Graphics Plane Pixel Format Unpacker

This block sits between the frame-buffer fetch path of a graphics plane and the downstream compositing logic. Each accepted input beat is one packed source word. A 2-bit count field states how many pixels the word holds. A 32-bit control word, captured together with the beat, selects the source format and three options: red/blue exchange, byte reversal within each pixel, and the range of 8-bit alpha. The block emits the pixels of the beat one at a time, lowest-addressed pixel first. Each output pixel is a 32-bit word with 8 bits per channel, laid out as alpha [31:24], red [23:16], green [15:8] and blue [7:0].

Channels narrower than 8 bits are widened by copying their top bits into the vacated low bits, so a full-scale field gives 0xFF and zero gives 0x00. Formats without alpha come out fully opaque. An unknown format code produces opaque black pixels and sets an error flag that stays set until reset. Both sides use valid/ready handshakes. A pixel waiting at the output stays unchanged until it is taken.

Top module: `pix_unpack`

## Requirements
- R1: Control bits [4:0] select the format. Byte lanes are numbered from the least significant bit of the pixel value. 0x00 is 16-bit R5G6B5 (red [15:11], green [10:5], blue [4:0]). 0x01 is 24-bit RGB (red [23:16], green [15:8], blue [7:0]). 0x02 is the same RGB in a 4-byte container whose top byte is ignored. 0x04 is 24-bit A8R5G6B5 (alpha [23:16], the 565 fields below it). 0x05 is 32-bit A8R8G8B8. 0x06 is 16-bit A1R5G5B5 (alpha [15], red [14:10], green [9:5], blue [4:0]). 0x07 is 16-bit A4R4G4B4 (alpha, red, green and blue in descending nibbles). The output is alpha [31:24], red [23:16], green [15:8], blue [7:0].
- R2: A 4-, 5- or 6-bit channel is widened to 8 bits by appending its most significant bits: {x,x} for 4 bits, {x,x[4:2]} for 5 bits, {x,x[5:4]} for 6 bits.
- R3: Codes 0x00, 0x01 and 0x02 output alpha 0xFF. The 1-bit alpha of code 0x06 outputs as 0x00 or 0xFF.
- R4: Control bit 5 set passes 8-bit alpha (codes 0x04 and 0x05) unchanged. Bit 5 clear treats that alpha as 0..128 and outputs min(2*a, 255). Bit 5 has no effect on any other format.
- R5: Control bit 6 exchanges the decoded red and blue channels.
- R6: Control bit 23 reverses the order of the bytes of each pixel (2, 3 or 4 bytes) before the fields are decoded.
- R7: A beat carries in_count+1 pixels. Pixel k starts at byte k*bpp of the word, where bpp is 2 for codes 0x00/0x06/0x07, 3 for 0x01/0x04, and 4 otherwise. The pixels are output in increasing k. The pixel count is clamped to the number of whole pixels that fit in the word.
- R8: An unknown code (0x03, or 0x08 to 0x1F) outputs 0xFF000000 for every pixel and sets fmt_err from the cycle after the beat is accepted. fmt_err stays set until reset.
- R9: While out_valid is high and out_ready is low, out_valid and out_pixel hold. Every pixel is delivered exactly once.
- R10: During and after reset, out_valid is 0, in_ready is 1 and fmt_err is 0.
- R11: The control word is sampled only when a beat is accepted. Later changes to it do not affect the pixels of that beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_ctrl | input | 32 | Format code and option bits, sampled with the beat |
| in_valid | input | 1 | Source beat valid |
| in_ready | output | 1 | Block can accept a beat |
| in_word | input | DATA_W | Packed source word |
| in_count | input | CNT_W | Pixels in the beat minus one |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Downstream takes the pixel |
| out_pixel | output | 32 | Expanded pixel, alpha/red/green/blue bytes |
| fmt_err | output | 1 | Sticky unknown-format flag |

## Verification
The assertions check the following on every cycle:
- a stalled output pixel does not change and stays valid;
- the error flag never clears;
- an unknown format always yields opaque black;
- opaque formats always carry alpha 0xFF;
- the pixel index never passes the clamped last pixel;
- an idle block is ready.

Only the bench scenarios can show:
- the decoded values of each format;
- the widening rule;
- the alpha doubling and saturation;
- the byte and channel swaps;
- the pixel order and count clamping within a word;
- that a control change after acceptance does not affect the beat.

// File: rtl/pfu_pkg.sv
package pfu_pkg;

   localparam int CTL_RANGE_BIT = 5;
   localparam int CTL_SWAP_BIT  = 6;
   localparam int CTL_BE_BIT    = 23;

   localparam logic [4:0] FC_RGB565   = 5'h00;
   localparam logic [4:0] FC_RGB24    = 5'h01;
   localparam logic [4:0] FC_RGB32    = 5'h02;
   localparam logic [4:0] FC_ARGB8565 = 5'h04;
   localparam logic [4:0] FC_ARGB32   = 5'h05;
   localparam logic [4:0] FC_ARGB1555 = 5'h06;
   localparam logic [4:0] FC_ARGB4444 = 5'h07;

   typedef struct packed {
      logic [4:0] code;
      logic [2:0] bpp;
      logic       known;
      logic       full_range;
      logic       swap;
      logic       big_end;
   } pix_cfg_t;

   typedef struct packed {
      logic [7:0] a;
      logic [7:0] r;
      logic [7:0] g;
      logic [7:0] b;
   } argb_t;

   function automatic logic [7:0] widen4(input logic [3:0] x);
      return {x, x};
   endfunction

   function automatic logic [7:0] widen5(input logic [4:0] x);
      return {x, x[4:2]};
   endfunction

   function automatic logic [7:0] widen6(input logic [5:0] x);
      return {x, x[5:4]};
   endfunction

endpackage

// File: rtl/pfu_fmt_decode.sv
module pfu_fmt_decode
   import pfu_pkg::*;
(
   input  logic [4:0] code,
   output logic [2:0] bpp,
   output logic       known
);

   always_comb begin
      known = 1'b1;
      unique case (code)
         FC_RGB565, FC_ARGB1555, FC_ARGB4444: bpp = 3'd2;
         FC_RGB24, FC_ARGB8565:               bpp = 3'd3;
         FC_RGB32, FC_ARGB32:                 bpp = 3'd4;
         default: begin
            bpp   = 3'd4;
            known = 1'b0;
         end
      endcase
   end

endmodule

// File: rtl/pfu_lane_pick.sv
module pfu_lane_pick #(
   parameter int DATA_W = 64,
   parameter int OFF_W  = 5
) (
   input  logic [DATA_W-1:0] word,
   input  logic [OFF_W-1:0]  byte_off,
   input  logic [2:0]        bpp,
   input  logic              big_end,
   output logic [31:0]       raw
);

   localparam int SH_W = OFF_W + 3;

   logic [DATA_W-1:0] shifted;
   logic [31:0]       lanes;
   logic [31:0]       rev4;
   logic [23:0]       rev3;
   logic [15:0]       rev2;
   logic              unused_hi;

   assign shifted = word >> {byte_off, 3'b000};

   generate
      if (DATA_W > 32) begin : g_wide
         assign lanes     = shifted[31:0];
         assign unused_hi = ^shifted[DATA_W-1:32];
      end else begin : g_narrow
         assign lanes     = shifted;
         assign unused_hi = 1'b0;
      end
   endgenerate

   // reversed byte orders for each pixel size
   generate
      for (genvar i = 0; i < 4; i++) begin : g_rev
         assign rev4[i*8 +: 8] = lanes[(3-i)*8 +: 8];
         if (i < 3) begin : g_r3
            assign rev3[i*8 +: 8] = lanes[(2-i)*8 +: 8];
         end
         if (i < 2) begin : g_r2
            assign rev2[i*8 +: 8] = lanes[(1-i)*8 +: 8];
         end
      end
   endgenerate

   always_comb begin
      if (!big_end) begin
         raw = lanes;
      end else begin
         unique case (bpp)
            3'd2:    raw = {16'h0000, rev2};
            3'd3:    raw = {8'h00, rev3};
            default: raw = rev4;
         endcase
      end
   end

   generate
      if (SH_W > 31) begin : g_bad_off
         $error("pfu_lane_pick: OFF_W too large");
      end
   endgenerate

endmodule

// File: rtl/pfu_expand.sv
module pfu_expand
   import pfu_pkg::*;
(
   input  pix_cfg_t    cfg,
   input  logic [31:0] v,
   output argb_t       px
);

   argb_t      dec;
   logic [7:0] a8;
   logic       has_a8;

   always_comb begin
      dec    = '0;
      a8     = 8'h00;
      has_a8 = 1'b0;
      unique case (cfg.code)
         FC_RGB565: begin
            dec.a = 8'hFF;
            dec.r = widen5(v[15:11]);
            dec.g = widen6(v[10:5]);
            dec.b = widen5(v[4:0]);
         end
         FC_RGB24, FC_RGB32: begin
            dec.a = 8'hFF;
            dec.r = v[23:16];
            dec.g = v[15:8];
            dec.b = v[7:0];
         end
         FC_ARGB8565: begin
            has_a8 = 1'b1;
            a8     = v[23:16];
            dec.r  = widen5(v[15:11]);
            dec.g  = widen6(v[10:5]);
            dec.b  = widen5(v[4:0]);
         end
         FC_ARGB32: begin
            has_a8 = 1'b1;
            a8     = v[31:24];
            dec.r  = v[23:16];
            dec.g  = v[15:8];
            dec.b  = v[7:0];
         end
         FC_ARGB1555: begin
            dec.a = {8{v[15]}};
            dec.r = widen5(v[14:10]);
            dec.g = widen5(v[9:5]);
            dec.b = widen5(v[4:0]);
         end
         FC_ARGB4444: begin
            dec.a = widen4(v[15:12]);
            dec.r = widen4(v[11:8]);
            dec.g = widen4(v[7:4]);
            dec.b = widen4(v[3:0]);
         end
         default: begin
            dec.a = 8'hFF;
         end
      endcase

      // 8-bit alpha: full range or 0..128 doubled with saturation
      if (has_a8) begin
         if (cfg.full_range)
            dec.a = a8;
         else if (a8[7])
            dec.a = 8'hFF;
         else
            dec.a = {a8[6:0], 1'b0};
      end

      px = dec;
      if (cfg.swap && cfg.known) begin
         px.r = dec.b;
         px.b = dec.r;
      end
   end

endmodule

// File: rtl/pfu_beat_hold.sv
module pfu_beat_hold
   import pfu_pkg::*;
#(
   parameter int DATA_W = 64,
   parameter int CNT_W  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [DATA_W-1:0] in_word,
   input  pix_cfg_t          in_cfg,
   input  logic [CNT_W-1:0]  in_last,
   input  logic              out_ready,
   output logic              hold_valid,
   output logic [DATA_W-1:0] hold_word,
   output pix_cfg_t          hold_cfg,
   output logic [CNT_W-1:0]  hold_idx,
   output logic [CNT_W-1:0]  hold_last
);

   logic at_last;
   logic accept;

   assign at_last  = (hold_idx == hold_last);
   assign in_ready = !hold_valid || (out_ready && at_last);
   assign accept   = in_valid && in_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_valid <= 1'b0;
         hold_word  <= '0;
         hold_cfg   <= '0;
         hold_idx   <= '0;
         hold_last  <= '0;
      end else if (accept) begin
         hold_valid <= 1'b1;
         hold_word  <= in_word;
         hold_cfg   <= in_cfg;
         hold_idx   <= '0;
         hold_last  <= in_last;
      end else if (hold_valid && out_ready) begin
         if (at_last)
            hold_valid <= 1'b0;
         else
            hold_idx <= hold_idx + 1'b1;
      end
   end

   // R9: a stalled beat keeps its word, configuration and position
   a_r9_stall_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      hold_valid && !out_ready |=> hold_valid && $stable(hold_idx) && $stable(hold_word));

   // R10: nothing held means the input side is open
   a_r10_idle_ready: assert property (@(posedge clk) disable iff (!rst_n)
      !hold_valid |-> in_ready);

   // R7: the pixel index stays within the clamped pixel count
   a_r7_idx_bound: assert property (@(posedge clk) disable iff (!rst_n)
      hold_valid |-> hold_idx <= hold_last);

endmodule

// File: rtl/pix_unpack.sv
module pix_unpack
   import pfu_pkg::*;
#(
   parameter int DATA_W = 64,
   parameter int CNT_W  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [31:0]       in_ctrl,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [DATA_W-1:0] in_word,
   input  logic [CNT_W-1:0]  in_count,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [31:0]       out_pixel,
   output logic              fmt_err
);

   localparam int BYTES   = DATA_W / 8;
   localparam int MAXPIX  = 1 << CNT_W;
   localparam int LAST2   = ((BYTES / 2) < MAXPIX ? (BYTES / 2) : MAXPIX) - 1;
   localparam int LAST3   = ((BYTES / 3) < MAXPIX ? (BYTES / 3) : MAXPIX) - 1;
   localparam int LAST4   = ((BYTES / 4) < MAXPIX ? (BYTES / 4) : MAXPIX) - 1;
   localparam int OFF_W   = $clog2(MAXPIX * 4 + 1);

   generate
      if (DATA_W % 32 != 0 || DATA_W < 32 || DATA_W > 256) begin : g_bad_data_w
         $error("pix_unpack: DATA_W must be a multiple of 32 within 32..256");
      end
      if (CNT_W < 1 || CNT_W > 4) begin : g_bad_cnt_w
         $error("pix_unpack: CNT_W must be 1..4");
      end
   endgenerate

   pix_cfg_t          new_cfg;
   logic [2:0]        new_bpp;
   logic              new_known;
   logic [CNT_W-1:0]  cap_last;
   logic [CNT_W-1:0]  new_last;
   logic              hold_valid;
   logic [DATA_W-1:0] hold_word;
   pix_cfg_t          hold_cfg;
   logic [CNT_W-1:0]  hold_idx;
   logic [CNT_W-1:0]  hold_last;
   logic [OFF_W-1:0]  byte_off;
   logic [31:0]       raw;
   argb_t             px;
   logic              err_q;
   logic              unused_ctl;

   assign unused_ctl = ^{in_ctrl[31:24], in_ctrl[22:7]};

   pfu_fmt_decode u_dec (
      .code  (in_ctrl[4:0]),
      .bpp   (new_bpp),
      .known (new_known)
   );

   always_comb begin
      new_cfg.code       = in_ctrl[4:0];
      new_cfg.bpp        = new_bpp;
      new_cfg.known      = new_known;
      new_cfg.full_range = in_ctrl[CTL_RANGE_BIT];
      new_cfg.swap       = in_ctrl[CTL_SWAP_BIT];
      new_cfg.big_end    = in_ctrl[CTL_BE_BIT];
      unique case (new_bpp)
         3'd2:    cap_last = CNT_W'(LAST2);
         3'd3:    cap_last = CNT_W'(LAST3);
         default: cap_last = CNT_W'(LAST4);
      endcase
      new_last = (in_count > cap_last) ? cap_last : in_count;
   end

   pfu_beat_hold #(
      .DATA_W (DATA_W),
      .CNT_W  (CNT_W)
   ) u_hold (
      .clk        (clk),
      .rst_n      (rst_n),
      .in_valid   (in_valid),
      .in_ready   (in_ready),
      .in_word    (in_word),
      .in_cfg     (new_cfg),
      .in_last    (new_last),
      .out_ready  (out_ready),
      .hold_valid (hold_valid),
      .hold_word  (hold_word),
      .hold_cfg   (hold_cfg),
      .hold_idx   (hold_idx),
      .hold_last  (hold_last)
   );

   assign byte_off = OFF_W'(hold_idx) * OFF_W'(hold_cfg.bpp);

   pfu_lane_pick #(
      .DATA_W (DATA_W),
      .OFF_W  (OFF_W)
   ) u_pick (
      .word     (hold_word),
      .byte_off (byte_off),
      .bpp      (hold_cfg.bpp),
      .big_end  (hold_cfg.big_end),
      .raw      (raw)
   );

   pfu_expand u_exp (
      .cfg (hold_cfg),
      .v   (raw),
      .px  (px)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         err_q <= 1'b0;
      else if (in_valid && in_ready && !new_known)
         err_q <= 1'b1;
   end

   assign out_valid = hold_valid;
   assign out_pixel = px;
   assign fmt_err   = err_q;

   // R9: a pixel that is not taken stays put
   a_r9_pixel_stable: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_pixel));

   // R8: the error flag never clears without reset
   a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      fmt_err |=> fmt_err);

   // R8: unknown format gives opaque black
   a_r8_bad_black: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !hold_cfg.known |-> out_pixel == 32'hFF00_0000);

   // R8: an unknown beat on the output implies the flag is already set
   a_r8_bad_flags: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !hold_cfg.known |-> fmt_err);

   // R3: formats without alpha are opaque
   a_r3_opaque: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && (hold_cfg.code == FC_RGB565 || hold_cfg.code == FC_RGB24 ||
                    hold_cfg.code == FC_RGB32) |-> out_pixel[31:24] == 8'hFF);

   // R3: one-bit alpha maps to an extreme
   a_r3_bit_alpha: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && hold_cfg.code == FC_ARGB1555 |->
         (out_pixel[31:24] == 8'h00 || out_pixel[31:24] == 8'hFF));

endmodule

// File: tb/pix_unpack_tb.sv
module pix_unpack_tb;

   localparam int DATA_W = 64;
   localparam int CNT_W  = 2;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [31:0]       in_ctrl = '0;
   logic              in_valid = 1'b0;
   logic              in_ready;
   logic [DATA_W-1:0] in_word = '0;
   logic [CNT_W-1:0]  in_count = '0;
   logic              out_valid;
   logic              out_ready = 1'b0;
   logic [31:0]       out_pixel;
   logic              fmt_err;

   int total = 0;
   int bad   = 0;

   always #2 clk = ~clk;

   pix_unpack #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_ctrl   (in_ctrl),
      .in_valid  (in_valid),
      .in_ready  (in_ready),
      .in_word   (in_word),
      .in_count  (in_count),
      .out_valid (out_valid),
      .out_ready (out_ready),
      .out_pixel (out_pixel),
      .fmt_err   (fmt_err)
   );

   // {ctrl, word, expected pixel}, one pixel per beat
   localparam logic [95:0] VEC [0:18] = '{
      {32'h0000_0000, 32'h0000_F800, 32'hFFFF_0000},   // R1 R2 565 red
      {32'h0000_0000, 32'h0000_07E0, 32'hFF00_FF00},   // R2 565 green
      {32'h0000_0000, 32'h0000_8410, 32'hFF84_8284},   // R2 replication
      {32'h0000_0001, 32'h0012_3456, 32'hFF12_3456},   // R1 24-bit
      {32'h0000_0002, 32'hAB12_3456, 32'hFF12_3456},   // R3 container byte ignored
      {32'h0000_0025, 32'h8012_3456, 32'h8012_3456},   // R4 full range
      {32'h0000_0005, 32'h4012_3456, 32'h8012_3456},   // R4 doubled
      {32'h0000_0005, 32'h80AB_CDEF, 32'hFFAB_CDEF},   // R4 saturate
      {32'h0000_0024, 32'h007F_F800, 32'h7FFF_0000},   // R1 8565 full
      {32'h0000_0004, 32'h0030_07E0, 32'h6000_FF00},   // R4 8565 doubled
      {32'h0000_0006, 32'h0000_8000, 32'hFF00_0000},   // R3 1555 alpha set
      {32'h0000_0006, 32'h0000_7C00, 32'h00FF_0000},   // R3 1555 alpha clear
      {32'h0000_0006, 32'h0000_0210, 32'h0000_8484},   // R2 1555 fields
      {32'h0000_0007, 32'h0000_9A5C, 32'h99AA_55CC},   // R2 4444
      {32'h0000_0027, 32'h0000_9A5C, 32'h99AA_55CC},   // R4 bit5 no effect
      {32'h0080_0042, 32'h1122_3344, 32'hFF11_2233},   // R5 R6 swapped 32-bit no alpha
      {32'h0080_0065, 32'h1122_3344, 32'h4411_2233},   // R5 R6 swapped 32-bit alpha
      {32'h0000_0040, 32'h0000_F800, 32'hFF00_00FF},   // R5 swap on 565
      {32'h0080_0001, 32'h0056_3412, 32'hFF12_3456}    // R6 24-bit reversal
   };

   task automatic check(input bit ok, input string tag,
                        input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
      end
   endtask

   task automatic send(input logic [31:0] ctl, input logic [DATA_W-1:0] w,
                       input logic [CNT_W-1:0] cnt);
      in_ctrl  = ctl;
      in_word  = w;
      in_count = cnt;
      in_valid = 1'b1;
      while (!in_ready) @(negedge clk);
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic recv(input logic [31:0] exp, input string tag);
      int w = 0;
      out_ready = 1'b1;
      while (!out_valid && w < 50) begin
         @(negedge clk);
         w++;
      end
      check(out_valid && out_pixel === exp, tag, out_pixel, exp);
      @(negedge clk);
      out_ready = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      bad++;
      $display("FAIL watchdog actual=%08h expected=%08h", 32'h0, 32'h1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R10: reset state
      check(!out_valid && in_ready && !fmt_err, "R10 reset state",
            {29'd0, out_valid, in_ready, fmt_err}, 32'h2);
      rst_n = 1'b1;
      @(negedge clk);
      check(!out_valid && in_ready && !fmt_err, "R10 after release",
            {29'd0, out_valid, in_ready, fmt_err}, 32'h2);

      for (int i = 0; i < 19; i++) begin
         send(VEC[i][95:64], {32'h0, VEC[i][63:32]}, 2'd0);
         recv(VEC[i][31:0], $sformatf("R1 vector %0d", i));
      end

      // R7: four 16-bit pixels, lowest first
      send(32'h0, 64'h001F_07E0_F800_FFFF, 2'd3);
      recv(32'hFFFF_FFFF, "R7 pixel 0");
      recv(32'hFF00_00FF == 32'h0 ? 32'h0 : 32'hFFFF_0000, "R7 pixel 1");
      recv(32'hFF00_FF00, "R7 pixel 2");
      recv(32'hFF00_00FF, "R7 pixel 3");
      check(!out_valid, "R7 no extra pixel", {31'd0, out_valid}, 32'h0);

      // R7: 24-bit count clamped to two pixels
      send(32'h1, 64'h0000_AABB_CC11_2233, 2'd3);
      recv(32'hFF11_2233, "R7 clamp pixel 0");
      recv(32'hFFAA_BBCC, "R7 clamp pixel 1");
      @(negedge clk);
      check(!out_valid && in_ready, "R7 clamp ends after two",
            {30'd0, out_valid, in_ready}, 32'h1);

      // R9 and R11: stall, then change the control word after acceptance
      send(32'h0, 64'h0000_0000_07E0_F800, 2'd1);
      in_ctrl = 32'h0000_0040;
      for (int k = 0; k < 5; k++) begin
         check(out_valid && out_pixel === 32'hFFFF_0000, "R9 stalled pixel held",
               out_pixel, 32'hFFFF_0000);
         @(negedge clk);
      end
      recv(32'hFFFF_0000, "R11 pixel 0 unaffected");
      recv(32'hFF00_FF00, "R11 pixel 1 unaffected");
      check(!out_valid, "R9 no duplicate", {31'd0, out_valid}, 32'h0);

      // R8: unknown formats
      check(!fmt_err, "R8 flag clear before", {31'd0, fmt_err}, 32'h0);
      send(32'h0000_0003, 64'h1234_5678, 2'd0);
      check(fmt_err, "R8 flag set", {31'd0, fmt_err}, 32'h1);
      recv(32'hFF00_0000, "R8 code 03 black");
      send(32'h0000_001F, 64'hFFFF_FFFF, 2'd0);
      recv(32'hFF00_0000, "R8 code 1F black");
      send(32'h1, 64'h0012_3456, 2'd0);
      recv(32'hFF12_3456, "R8 good after bad");
      check(fmt_err, "R8 flag sticky", {31'd0, fmt_err}, 32'h1);

      // R10: reset in the middle of a beat clears output and flag
      send(32'h0, 64'h0000_0000_1234_5678, 2'd1);
      rst_n = 1'b0;
      @(negedge clk);
      check(!out_valid && in_ready && !fmt_err, "R10 reset mid beat",
            {29'd0, out_valid, in_ready, fmt_err}, 32'h2);
      rst_n = 1'b1;
      @(negedge clk);
      check(!out_valid, "R10 nothing after reset", {31'd0, out_valid}, 32'h0);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule